// File: doc/BRIEF.md
# Upper-Triangular Matrix Inverter

This block inverts an upper-triangular matrix whose active size is chosen at run time, from 1x1 up to a parameterised maximum (24x24 by default). A start pulse captures the active size N. The matrix then arrives one element per handshake beat, in column order. The block stores the columns it receives. After each column arrives, the block solves for the matching column of the inverse by back substitution. Each step reuses inverse columns that are already finished.

For each column, the block forms one reciprocal of the diagonal element with a serial restoring divider. It then multiplies every off-diagonal entry of that column by this reciprocal, so it never divides those entries one by one. Values are signed fixed point, 18 bits wide with 12 fractional bits. Sums of products are kept at full width and are rounded only when an entry is stored. After the last column is solved, the whole inverse is sent out in row order, with a last flag on the final element. A zero on the diagonal sets an error flag that stays set until the next start.

Top module: `tri_inv_top`

## Requirements
- R1: During and after reset, out_valid, in_ready and err are all 0.
- R2: After start, the block accepts exactly N*N input beats. Beat number c*N+r carries element (row r, column c). in_ready is 1 only while the block is collecting a column.
- R3: Input elements below the diagonal (row > column) have no effect on any output value.
- R4: A diagonal output entry (m,m) equals the reciprocal of R(m,m). Its magnitude is floor(2^24/|R(m,m)|), limited to 131071, and it takes the sign of R(m,m).
- R5: An entry above the diagonal, (n,m) with n<m, is computed in three steps. First form s, the full-width sum of Rinv(n,k)*R(k,m) for k from n to m-1. Then round s. Finally, the entry is the rounded value of -(rounded s)*Rinv(m,m). Rounding means: add 2^11, shift right arithmetically by 12, and saturate to the range -131072 to 131071.
- R6: out_valid stays 0 until every column of the inverse has been computed. While the result is being sent, in_ready stays 0.
- R7: The output holds N*N elements in row order, so element (r,c) is beat r*N+c. Every entry below the diagonal is sent as 0.
- R8: out_last is 1 on the final output element only.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values.
- R10: A zero diagonal element sets err to 1, and the matching reciprocal becomes 131071. err stays set through the output and clears on the next start.
- R11: Runs of different sizes, including N=1 and the maximum size, may follow one another without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run while the block is idle and captures size |
| size | input | 5 | Active matrix dimension N, from 1 to MAXN |
| in_valid | input | 1 | An input element is present |
| in_ready | output | 1 | Block takes the element on this edge |
| in_data | input | 18 | Input element, signed Q6.12 |
| out_valid | output | 1 | An output element is present |
| out_ready | input | 1 | Consumer takes the output element |
| out_data | output | 18 | Inverse element, signed Q6.12 |
| out_last | output | 1 | Marks the final element of the inverse |
| err | output | 1 | Sticky flag for a zero diagonal element |

## Verification
The assertions assume that start is pulsed only while the block is idle and that size lies between 1 and MAXN. The divider is assumed to start only when it is not already running. The bench drives start only after the previous result has been drained, and it uses sizes 1, 2, 3, 4, 5 and 24. Input values are fed in strict column order; below-diagonal slots are filled with random values to show they are ignored. out_ready is either held high or toggled in a pattern, which exercises the output hold rule.

// File: rtl/tri_inv_pkg.sv
package tri_inv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_DIV, S_MRD, S_MACC, S_SCALE, S_DIAG, S_ORD, S_OCAP, S_OVAL
  } tri_state_e;
endpackage

// File: rtl/tri_ram.sv
module tri_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 576,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tri_recip.sv
module tri_recip #(
  parameter int DW = 18,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] d,
  output logic          done,
  output logic [DW-1:0] q,
  output logic          zero
);
  localparam int QW = 2*FW + 1;
  localparam int CW = $clog2(QW + 1);
  localparam logic [QW-1:0] QMAX = QW'((1 << (DW-1)) - 1);

  logic [DW-1:0] dabs;
  logic [DW:0]   rem;
  logic [DW:0]   trial;
  logic [QW-1:0] quo;
  logic [CW-1:0] cnt;
  logic          run, neg;
  logic [DW-1:0] mag;

  assign trial = {rem[DW-1:0], (cnt == CW'(QW))};

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; done <= 1'b0; cnt <= '0; rem <= '0; quo <= '0;
      dabs <= '0; neg <= 1'b0;
    end else begin
      done <= run && (cnt == CW'(1));
      if (go) begin
        dabs <= d[DW-1] ? (~d + DW'(1)) : d;
        neg  <= d[DW-1];
        rem  <= '0;
        quo  <= '0;
        cnt  <= CW'(QW);
        run  <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, dabs}) begin
          rem <= trial - {1'b0, dabs};
          quo <= {quo[QW-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[QW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) run <= 1'b0;
      end
    end
  end

  assign zero = (dabs == '0);
  assign mag  = (zero || quo > QMAX) ? QMAX[DW-1:0] : quo[DW-1:0];
  assign q    = neg ? (~mag + DW'(1)) : mag;

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_go_when_free_r4: assert property (@(posedge clk) disable iff (rst)
    go |-> !run);
endmodule

// File: rtl/tri_inv_top.sv
module tri_inv_top
  import tri_inv_pkg::*;
#(
  parameter int MAXN = 24,
  parameter int DW   = 18,
  parameter int FW   = 12,
  parameter int SW   = $clog2(MAXN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] size,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          err
);
  localparam int DEPTH = MAXN * MAXN;
  localparam int AW    = $clog2(DEPTH);
  localparam int ACCW  = 2*DW + $clog2(MAXN) + 1;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FW-1);
  localparam logic signed [ACCW-1:0] MAXP = (ACCW'(1) <<< (DW-1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] MINN = -(ACCW'(1) <<< (DW-1));

  function automatic logic [AW-1:0] at(input logic [SW-1:0] i, input logic [SW-1:0] j);
    return AW'(int'(i) * MAXN + int'(j));
  endfunction

  function automatic logic [DW-1:0] rnd(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] t;
    t = (a + HALF) >>> FW;
    if (t > MAXP) return MAXP[DW-1:0];
    else if (t < MINN) return MINN[DW-1:0];
    else return t[DW-1:0];
  endfunction

  tri_state_e st;
  logic [SW-1:0] nsz, lastix, row, col, n, k;
  logic [DW-1:0] diag_q, recip;
  logic signed [ACCW-1:0] acc;
  logic div_go, div_done, div_zero;
  logic [DW-1:0] div_q;
  logic [DW-1:0] r_rd, inv_rd;
  logic signed [2*DW-1:0] mac_p, sc_p;
  logic [DW-1:0] tmp, ent;
  logic signed [ACCW-1:0] sc_neg;
  logic out_ph;

  assign lastix = nsz - SW'(1);
  assign in_ready = (st == S_LOAD);
  assign out_ph = (st == S_ORD) || (st == S_OCAP) || (st == S_OVAL);

  tri_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rmem (
    .clk(clk), .we(st == S_LOAD && in_valid && row <= col),
    .waddr(at(row, col)), .wdata(in_data), .raddr(at(k, col)), .rdata(r_rd));

  tri_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_imem (
    .clk(clk), .we(st == S_SCALE || st == S_DIAG),
    .waddr(st == S_SCALE ? at(n, col) : at(col, col)),
    .wdata(st == S_SCALE ? ent : recip),
    .raddr(out_ph ? at(row, col) : at(n, k)), .rdata(inv_rd));

  tri_recip #(.DW(DW), .FW(FW)) u_recip (
    .clk(clk), .rst(rst), .go(div_go), .d(diag_q),
    .done(div_done), .q(div_q), .zero(div_zero));

  assign mac_p  = $signed(inv_rd) * $signed(r_rd);
  assign tmp    = rnd(acc);
  assign sc_p   = $signed(tmp) * $signed(recip);
  assign sc_neg = -{{(ACCW-2*DW){sc_p[2*DW-1]}}, sc_p};
  assign ent    = rnd(sc_neg);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; nsz <= SW'(1); row <= '0; col <= '0; n <= '0; k <= '0;
      diag_q <= '0; recip <= '0; acc <= '0; div_go <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0; err <= 1'b0;
    end else begin
      div_go <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          nsz <= size; row <= '0; col <= '0; err <= 1'b0; st <= S_LOAD;
        end
        S_LOAD: if (in_valid) begin
          if (row == col) diag_q <= in_data;
          if (row == lastix) begin
            row <= '0; div_go <= 1'b1; st <= S_DIV;
          end else row <= row + SW'(1);
        end
        S_DIV: if (div_done) begin
          recip <= div_q;
          if (div_zero) err <= 1'b1;
          n <= '0; k <= '0; acc <= '0;
          st <= (col == '0) ? S_DIAG : S_MRD;
        end
        S_MRD: st <= S_MACC;
        S_MACC: begin
          acc <= acc + {{(ACCW-2*DW){mac_p[2*DW-1]}}, mac_p};
          if (k == col - SW'(1)) st <= S_SCALE;
          else begin k <= k + SW'(1); st <= S_MRD; end
        end
        S_SCALE: begin
          acc <= '0;
          if (n == col - SW'(1)) st <= S_DIAG;
          else begin n <= n + SW'(1); k <= n + SW'(1); st <= S_MRD; end
        end
        S_DIAG: begin
          row <= '0;
          if (col == lastix) begin col <= '0; st <= S_ORD; end
          else begin col <= col + SW'(1); st <= S_LOAD; end
        end
        S_ORD: st <= S_OCAP;
        S_OCAP: begin
          out_data  <= (row > col) ? '0 : inv_rd;
          out_last  <= (row == lastix) && (col == lastix);
          out_valid <= 1'b1;
          st <= S_OVAL;
        end
        S_OVAL: if (out_ready) begin
          out_valid <= 1'b0; out_last <= 1'b0;
          if (col == lastix) begin col <= '0; row <= row + SW'(1); end
          else col <= col + SW'(1);
          st <= out_last ? S_IDLE : S_ORD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_in_during_out_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  p_below_zero_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && (row > col) |-> out_data == '0);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err && !(st == S_IDLE && start) |=> err);
  p_size_range_r2: assert property (@(posedge clk) disable iff (rst)
    st == S_IDLE && start |-> size >= SW'(1) && int'(size) <= MAXN);
endmodule

// File: tb/sim_tri_inv_top.sv
module sim_tri_inv_top;
  localparam int MAXN = 24;
  localparam int DW = 18;
  localparam int SW = $clog2(MAXN + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [SW-1:0] size = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, err;
  logic [DW-1:0] out_data;
  int total = 0, bad = 0;
  int R [MAXN][MAXN];
  int E [MAXN][MAXN];

  always #4 clk = ~clk;

  tri_inv_top #(.MAXN(MAXN), .DW(DW), .FW(12), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .start(start), .size(size), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .err(err));

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int rnd(longint a);
    longint t = (a + 2048) >>> 12;
    if (t > 131071) return 131071;
    if (t < -131072) return -131072;
    return int'(t);
  endfunction

  function automatic int recip(int d);
    longint a, q;
    if (d == 0) return 131071;
    a = (d < 0) ? -d : d;
    q = (longint'(1) << 24) / a;
    if (q > 131071) q = 131071;
    return (d < 0) ? int'(-q) : int'(q);
  endfunction

  task automatic model(int n);
    for (int m = 0; m < n; m++) begin
      int rc = recip(R[m][m]);
      for (int i = 0; i < m; i++) begin
        longint s = 0;
        for (int k = i; k < m; k++) s += longint'(E[i][k]) * R[k][m];
        E[i][m] = rnd(-(longint'(rnd(s)) * rc));
      end
      E[m][m] = rc;
      for (int i = m + 1; i < n; i++) E[i][m] = 0;
    end
  endtask

  task automatic fill(int n);
    for (int c = 0; c < n; c++)
      for (int r = 0; r < n; r++) begin
        if (r == c) begin
          R[r][c] = 2048 + int'($urandom % 6144);
          if ($urandom % 2 == 1) R[r][c] = -R[r][c];
        end else if (r < c) R[r][c] = int'($urandom % 4096) - 2048;
        else R[r][c] = 0;
      end
  endtask

  // One full run: start, column-order input, row-order output with checks.
  task automatic run_case(string nm, int n, int rmode, int exp_err);
    int early = 0, idx = 0, cyc = 0;
    model(n);
    @(negedge clk);
    size = SW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({nm, " R10 err cleared by start"}, int'(err), 0);
    for (int c = 0; c < n; c++)
      for (int r = 0; r < n; r++) begin
        in_valid = 1'b1;
        in_data = (r <= c) ? DW'(R[r][c]) : DW'($urandom | 1);  // R3 garbage below
        while (!in_ready) begin
          if (out_valid) early++;
          @(negedge clk);
        end
        @(negedge clk);
      end
    in_valid = 1'b0;
    chk({nm, " R2 in_ready drops after N*N beats"}, int'(in_ready), 0);
    while (idx < n * n) begin
      if (out_valid && in_ready) early++;
      cyc++;
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (out_valid && out_ready) begin
        int r = idx / n, c = idx % n;
        string tg = (r == c) ? " R4 diag" : ((r < c) ? " R5 upper" : " R7 lower zero");
        chk($sformatf("%s%s (%0d,%0d)", nm, tg, r, c), int'($signed(out_data)), E[r][c]);
        chk({nm, " R8 last flag"}, int'(out_last), int'(idx == n * n - 1));
        idx++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk({nm, " R6 no early output"}, early, 0);
    chk({nm, " R10 err flag"}, int'(err), exp_err);
    repeat (3) @(negedge clk);
    chk({nm, " R6 idle after output"}, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 0);
    chk("R1 err in reset", int'(err), 0);
  endtask

  task automatic t_one;  // R11 smallest size
    R[0][0] = 8192;
    run_case("n1", 1, 0, 0);
  endtask

  task automatic t_neg;
    R[0][0] = -4096; R[0][1] = 2048; R[1][0] = 0; R[1][1] = 8192;
    run_case("n2neg", 2, 1, 0);
  endtask

  task automatic t_garbage;  // R3 below-diagonal inputs random
    fill(4);
    run_case("n4 R3", 4, 0, 0);
  endtask

  task automatic t_zero;  // R10 zero pivot
    fill(5);
    R[2][2] = 0;
    run_case("n5zero", 5, 0, 1);
  endtask

  task automatic t_after_err;  // R10 err clears, R9 backpressure
    fill(3);
    run_case("n3 R9", 3, 1, 0);
  endtask

  task automatic t_full;  // R11 maximum size
    fill(MAXN);
    run_case("n24", MAXN, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_one();
    t_neg();
    t_garbage();
    t_zero();
    t_after_err();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule